// File: doc/BRIEF.md
# PCIe Link Health Monitor with Gen2 Stall Recovery

The block runs one link health check each time it receives a start pulse. It samples two PHY debug words. The first debug word carries the 6-bit training-state code. The second carries a link-up flag and an in-training flag. From these flags the block sorts the link into one of three cases: down, up but still training, or up and settled. A settled link is reported good at once. A link that is still training is sampled again, up to five more times, with a programmable gap between samples.

A link that is down, or that never finishes training, takes the fallback path. On this path the block reads the PHY receiver-valid register through an external request/done access port. The link may be stuck entering Gen2: the receiver is not valid and the training state shows the receiver-lock phase of recovery. In that case the block sets two receiver override enables with a read-modify-write, holds them for a programmable time, and then clears them with a second read-modify-write. Every check that ends on the fallback path reports the link as not good. The PHY access sequencer and the training state machine are outside this block. All millisecond waits are counted in clock cycles by parameters, so they can be shortened for simulation.

Top module: `link_health_mon`

## Requirements
- R1: A sample with bit 4 (link up) of `dbg1_word` set and bit 29 (in training) clear ends the check as good. `res_valid` pulses on the cycle after that sample, and no PHY access is made.
- R2: A sample with link up and in training set is repeated after `RETRY_GAP` cycles, at most 5 more times (6 samples in all). If the 6th sample still shows training, the check takes the fallback path.
- R3: The fallback path (link-up clear, or training not finished) reads PHY address 0x100D. If bit 0 (receiver valid) of the read data is set, the check ends not good and makes no further access.
- R4: Recovery starts only when the 0x100D read returns bit 0 clear and `dbg0_word[5:0]` equals 0x0D in the cycle the read completes. The upper bits of `dbg0_word` are ignored. In every other case the check ends not good after that single read.
- R5: Recovery reads PHY address 0x1005 and writes back the read value with bits 5 and 3 set (mask 0x0028). It then waits `RECOVER_WAIT` cycles, reads 0x1005 again, and writes back the value with bits 5 and 3 cleared. Only address 0x1005 is ever written.
- R6: A check that ends on the fallback path reports `link_good`=0, whether recovery ran or not.
- R7: While `phy_req` is high and `phy_done` is low, `phy_req`, `phy_we`, `phy_addr` and `phy_wdata` hold steady. `phy_done` together with `phy_err` aborts the check with `link_good`=0 and no further access.
- R8: After reset, `busy`, `phy_req`, `res_valid` and `link_good` are 0. A start pulse is taken only while idle and is ignored while busy. `res_valid` is a single-cycle pulse, and `link_good` holds the last verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a health check (taken when idle) |
| dbg0_word | input | 32 | PHY debug word; bits 5:0 hold the training-state code |
| dbg1_word | input | 32 | PHY debug word; bit 4 link up, bit 29 in training |
| phy_req | output | 1 | PHY register access request |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_done | input | 1 | Access completed (one-cycle pulse) |
| phy_err | input | 1 | Access failed, valid with phy_done |
| phy_rdata | input | 16 | PHY read data, valid with phy_done |
| busy | output | 1 | A check is in progress |
| res_valid | output | 1 | One-cycle pulse: verdict is ready |
| link_good | output | 1 | Verdict of the last finished check |

## Verification
A wrong internal state shows up at the ports quickly. It appears as a verdict pulse one cycle early or late, as a PHY request that starts or ends one cycle off, or as a missing or extra read or write of 0x1005. The bench compares all of these against a behavioural model on every clock, so a divergence is reported within one cycle of when it occurs. The retry count and the two wait windows are checked through the cycle on which the fallback read or the clearing read starts. The override bit arithmetic is checked through the values the bench's PHY model receives.

// File: rtl/link_health_mon.sv
module link_health_mon #(
  parameter int RETRY_MAX    = 5,
  parameter int RETRY_GAP    = 150000,
  parameter int RECOVER_WAIT = 250000,
  parameter int UP_BIT       = 4,
  parameter int TRAIN_BIT    = 29,
  parameter int STATE_W      = 6,
  parameter logic [5:0]  STUCK_CODE = 6'h0D,
  parameter logic [15:0] RXV_ADDR   = 16'h100D,
  parameter logic [15:0] OVR_ADDR   = 16'h1005,
  parameter int RXV_BIT      = 0,
  parameter logic [15:0] OVR_MASK   = 16'h0028
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] dbg0_word,
  input  logic [31:0] dbg1_word,
  output logic        phy_req,
  output logic        phy_we,
  output logic [15:0] phy_addr,
  output logic [15:0] phy_wdata,
  input  logic        phy_done,
  input  logic        phy_err,
  input  logic [15:0] phy_rdata,
  output logic        busy,
  output logic        res_valid,
  output logic        link_good
);

  localparam int TMR_MAX = (RETRY_GAP > RECOVER_WAIT) ? RETRY_GAP : RECOVER_WAIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int CNT_W   = $clog2(RETRY_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SAMPLE, S_GAP, S_RD_RXV, S_RD_SET, S_WR_SET, S_HOLD, S_RD_CLR, S_WR_CLR
  } st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] tries;
  logic [15:0]      wr_val;

  wire link_up  = dbg1_word[UP_BIT];
  wire in_train = dbg1_word[TRAIN_BIT];
  wire stuck    = (dbg0_word[STATE_W-1:0] == STUCK_CODE);

  logic unused_bits;
  assign unused_bits = ^{dbg0_word[31:STATE_W], dbg1_word};

  assign busy      = (st != S_IDLE);
  assign phy_req   = (st == S_RD_RXV) || (st == S_RD_SET) || (st == S_WR_SET) ||
                     (st == S_RD_CLR) || (st == S_WR_CLR);
  assign phy_we    = (st == S_WR_SET) || (st == S_WR_CLR);
  assign phy_addr  = (st == S_RD_RXV) ? RXV_ADDR : OVR_ADDR;
  assign phy_wdata = wr_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      tries     <= '0;
      wr_val    <= '0;
      res_valid <= 1'b0;
      link_good <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st    <= S_SAMPLE;
            tries <= '0;
          end
        S_SAMPLE:
          if (link_up && !in_train) begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            link_good <= 1'b1;
          end else if (link_up && tries != CNT_W'(RETRY_MAX)) begin
            tries <= tries + 1'b1;
            tmr   <= TMR_W'(RETRY_GAP - 1);
            st    <= S_GAP;
          end else begin
            st <= S_RD_RXV;
          end
        S_GAP:
          if (tmr == '0) st <= S_SAMPLE;
          else           tmr <= tmr - 1'b1;
        S_RD_RXV:
          if (phy_done) begin
            if (phy_err || phy_rdata[RXV_BIT] || !stuck) begin
              st        <= S_IDLE;
              res_valid <= 1'b1;
              link_good <= 1'b0;
            end else begin
              st <= S_RD_SET;
            end
          end
        S_RD_SET:
          if (phy_done) begin
            if (phy_err) begin
              st        <= S_IDLE;
              res_valid <= 1'b1;
              link_good <= 1'b0;
            end else begin
              wr_val <= phy_rdata | OVR_MASK;
              st     <= S_WR_SET;
            end
          end
        S_WR_SET:
          if (phy_done) begin
            if (phy_err) begin
              st        <= S_IDLE;
              res_valid <= 1'b1;
              link_good <= 1'b0;
            end else begin
              tmr <= TMR_W'(RECOVER_WAIT - 1);
              st  <= S_HOLD;
            end
          end
        S_HOLD:
          if (tmr == '0) st <= S_RD_CLR;
          else           tmr <= tmr - 1'b1;
        S_RD_CLR:
          if (phy_done) begin
            if (phy_err) begin
              st        <= S_IDLE;
              res_valid <= 1'b1;
              link_good <= 1'b0;
            end else begin
              wr_val <= phy_rdata & ~OVR_MASK;
              st     <= S_WR_CLR;
            end
          end
        S_WR_CLR:
          if (phy_done) begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            link_good <= 1'b0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_GOOD_NEEDS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && link_good) |-> $past(link_up && !in_train)); // R1
  AST_WRITE_ONLY_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_we) |-> (phy_addr == OVR_ADDR)); // R5
  AST_WRITE_MASK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_we) |-> ((phy_wdata & OVR_MASK) == OVR_MASK || (phy_wdata & OVR_MASK) == 16'h0)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_done) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))); // R7
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_done && phy_err) |=> (res_valid && !link_good && !phy_req)); // R7
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !phy_req); // R8

endmodule

// File: tb/link_health_mon_tb.sv
module link_health_mon_tb;
  localparam int G = 20;
  localparam int W = 50;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] dbg0_word = '0, dbg1_word = '0;
  logic phy_req, phy_we, phy_done = 1'b0, phy_err = 1'b0;
  logic [15:0] phy_addr, phy_wdata, phy_rdata = '0;
  logic busy, res_valid, link_good;

  always #5 clk = ~clk;

  link_health_mon #(.RETRY_GAP(G), .RECOVER_WAIT(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dbg0_word(dbg0_word), .dbg1_word(dbg1_word),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_done(phy_done), .phy_err(phy_err), .phy_rdata(phy_rdata),
    .busy(busy), .res_valid(res_valid), .link_good(link_good));

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // PHY register model and responder
  logic [15:0] rxv_reg = '0, ovr_reg = '0;
  int n_rd = 0, n_wr = 0, n_res = 0, lat = 0;
  bit err_arm = 0;
  logic [15:0] wlog[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      phy_done <= 1'b0; phy_err <= 1'b0; lat = 0;
    end else if (phy_done) begin
      phy_done <= 1'b0; phy_err <= 1'b0;
    end else if (phy_req) begin
      if (lat == LAT) begin
        lat = 0;
        phy_done <= 1'b1;
        if (!phy_we) n_rd++;
        if (err_arm) begin
          phy_err <= 1'b1; err_arm = 0;
        end else if (phy_we) begin
          n_wr++; wlog.push_back(phy_wdata);
          if (phy_addr == 16'h1005) ovr_reg = phy_wdata;
        end else begin
          phy_rdata <= (phy_addr == 16'h100D) ? rxv_reg : ovr_reg;
        end
      end else lat++;
    end
    if (rst_n && res_valid) n_res++;
  end

  // behavioural reference model, stepped on each rising edge
  int mst = 0, tries = 0, mcnt = 0;
  logic [15:0] mwv = '0;
  bit mv = 0, mg = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; tries = 0; mcnt = 0; mwv = '0; mv = 0; mg = 0;
    end else begin
      mv = 0;
      case (mst)
        0: if (start) begin mst = 1; tries = 0; end
        1: if (dbg1_word[4] && !dbg1_word[29]) begin mv = 1; mg = 1; mst = 0; end
           else if (dbg1_word[4] && tries < 5) begin tries++; mcnt = G; mst = 2; end
           else mst = 3;
        2: begin mcnt--; if (mcnt == 0) mst = 1; end
        3: if (phy_done) begin
             if (phy_err || phy_rdata[0] || dbg0_word[5:0] != 6'h0D) begin mv = 1; mg = 0; mst = 0; end
             else mst = 4;
           end
        4: if (phy_done) begin
             if (phy_err) begin mv = 1; mg = 0; mst = 0; end
             else begin mwv = phy_rdata | 16'h0028; mst = 5; end
           end
        5: if (phy_done) begin
             if (phy_err) begin mv = 1; mg = 0; mst = 0; end
             else begin mcnt = W; mst = 6; end
           end
        6: begin mcnt--; if (mcnt == 0) mst = 7; end
        7: if (phy_done) begin
             if (phy_err) begin mv = 1; mg = 0; mst = 0; end
             else begin mwv = phy_rdata & ~16'h0028; mst = 8; end
           end
        8: if (phy_done) begin mv = 1; mg = 0; mst = 0; end
        default: mst = 0;
      endcase
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      bit ereq, ewe;
      ereq = (mst >= 3 && mst <= 5) || mst == 7 || mst == 8;
      ewe  = (mst == 5) || (mst == 8);
      chk(busy == (mst != 0), "R8", "busy", busy, mst != 0);
      chk(res_valid == mv && link_good == mg, "R1", "verdict", {res_valid, link_good}, {mv, mg});
      chk(phy_req == ereq, "R7", "phy_req", phy_req, ereq);
      if (ereq) begin
        chk(phy_we == ewe, "R7", "phy_we", phy_we, ewe);
        chk(phy_addr == ((mst == 3) ? 16'h100D : 16'h1005), "R5", "phy_addr", phy_addr,
            (mst == 3) ? 16'h100D : 16'h1005);
        if (ewe) chk(phy_wdata == mwv, "R5", "phy_wdata", phy_wdata, mwv);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int first_req;

  task automatic run(input bit exp_good, input int exp_rd, input int exp_wr,
                     input string req, input int poke);
    int r0;
    n_rd = 0; n_wr = 0; wlog.delete(); first_req = -1;
    r0 = n_res;
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      start = (k == poke);
      if (phy_req && first_req < 0) first_req = k;
      if (res_valid) break;
    end
    start = 1'b0;
    chk(res_valid === 1'b1, req, "result seen", res_valid, 1);
    chk(link_good === exp_good, req, "link_good", link_good, exp_good);
    chk(n_rd == exp_rd, req, "phy reads", n_rd, exp_rd);
    chk(n_wr == exp_wr, req, "phy writes", n_wr, exp_wr);
    repeat (30) @(negedge clk);
    chk(n_res - r0 == 1, "R8", "verdict pulses", n_res - r0, 1);
    chk(busy == 1'b0, "R8", "idle after check", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && phy_req == 0 && res_valid == 0 && link_good == 0, "R8", "reset state",
        {busy, phy_req, res_valid, link_good}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: settled link
    dbg1_word = 32'h0000_0010;
    run(1, 0, 0, "R1", -1);
    dbg1_word = 32'hDFFF_FFFF;
    run(1, 0, 0, "R1", -1);

    // R3: link down, receiver valid
    dbg1_word = 32'h0; rxv_reg = 16'h0001; dbg0_word = 32'h0D;
    run(0, 1, 0, "R3", -1);

    // R2: training clears after two re-samples
    dbg1_word = 32'h2000_0010;
    fork
      run(1, 0, 0, "R2", -1);
      begin repeat (45) @(negedge clk); dbg1_word = 32'h0000_0010; end
    join

    // R2 boundary and R8 start-while-busy: training never ends
    dbg1_word = 32'h2000_0010; rxv_reg = 16'h0001;
    run(0, 1, 0, "R2", 30);
    chk(first_req >= 5 * G && first_req < 6 * G, "R2", "fallback read cycle", first_req, 5 * G);

    // R4: receiver not valid but state is not the stuck code
    dbg1_word = 32'h0; rxv_reg = 16'h0000; dbg0_word = 32'h0C;
    run(0, 1, 0, "R4", -1);

    // R5/R6: recovery
    dbg0_word = 32'h0D; ovr_reg = 16'h0041;
    run(0, 3, 2, "R6", -1);
    chk(wlog.size() == 2 && wlog[0] == 16'h0069, "R5", "set write", wlog.size() > 0 ? wlog[0] : 0, 16'h0069);
    chk(wlog.size() == 2 && wlog[1] == 16'h0041, "R5", "clear write", wlog.size() > 1 ? wlog[1] : 0, 16'h0041);

    // R4: upper debug bits ignored; R5 with bits already set
    dbg0_word = 32'hABCD_EF0D; rxv_reg = 16'hFFFE; ovr_reg = 16'h0FFF;
    run(0, 3, 2, "R4", -1);
    chk(ovr_reg == 16'h0FD7, "R5", "final override value", ovr_reg, 16'h0FD7);

    // R7: error on receiver-valid read aborts a would-be recovery
    dbg0_word = 32'h0D; rxv_reg = 16'h0000; ovr_reg = 16'h0041; err_arm = 1;
    run(0, 1, 0, "R7", -1);
    chk(ovr_reg == 16'h0041, "R7", "override untouched", ovr_reg, 16'h0041);

    // R1 again: verdict becomes good after bad ones
    dbg1_word = 32'h0000_0010;
    run(1, 0, 0, "R1", -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule